// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block decides which pending exception the CPU takes next. It watches one non-maskable request, six external interrupt lines, 27 internal peripheral request lines and a trap request with a 2-bit trap number. Each cycle it picks a single winner. It registers that winner's vector number together with an accept strobe toward the CPU sequencer, and holds both until the sequencer acknowledges.

Every maskable source belongs to a priority group. Each group has one level bit in one of two writable 8-bit priority registers. A level-1 request beats any level-0 request. Within a level, the lowest vector number wins.

The CPU passes in its current mask bits (I and UI) and a mode bit. The block uses them to filter the maskable sources. It also reports the mask values the CPU must load on exception entry.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `accept` is 0, `vec_num` is 0, `new_imask` and `new_umask` are 0, and every priority group is at level 0.
- R2: A non-maskable request always wins with vector 7, whatever the mask bits, the trap request or other requests are.
- R3: A trap request with number n wins over all maskable sources with vector 8+n and is never masked; it loses only to the non-maskable request.
- R4: Vector numbers are as follows. External line n (`ext_req[n]`) uses 12+n. Internal line k (`int_req[k]`) uses 20+k. The internal lines are ordered: watchdog k=0, 16-bit timer k=1..9, 8-bit timer k=10..17, serial k=18..25, A/D k=26.
- R5: Among enabled requests at the same level, the one with the lowest vector number wins.
- R6: A level-1 request beats any level-0 request. A register-A write (`prio_wr_a`) loads the level bits of the groups below:
  - bits 0..5: external lines 0..5
  - bit 6: watchdog
  - bit 7: A/D

  A register-B write (`prio_wr_b`) loads the rest:
  - bits 0..2: 16-bit timer k=1..3, 4..6 and 7..9
  - bits 3..4: 8-bit timer k=10..13 and 14..17
  - bits 5..6: serial k=18..21 and 22..25
  - bit 7 is ignored
- R7: With `ue_mode`=1, `cpu_imask`=1 masks every maskable source.
- R8: With `ue_mode`=0, `cpu_imask`=1 masks level-0 sources. Level-1 sources are masked only when `cpu_imask` and `cpu_umask` are both 1.
- R9: `accept` and `vec_num` rise on the clock edge that samples a winning request. They then hold, ignoring new requests, until the edge that samples `ack`=1, which clears `accept`. Arbitration resumes on the following edge.
- R10: When a winner is captured, `new_imask` becomes 1. `new_umask` becomes 1 when `ue_mode`=0 and a copy of `cpu_umask` when `ue_mode`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prio_wr_a | input | 1 | Write strobe for priority register A |
| prio_wr_b | input | 1 | Write strobe for priority register B |
| prio_wdata | input | 8 | Priority register write data |
| nmi_req | input | 1 | Non-maskable request |
| ext_req | input | 6 | External interrupt lines |
| int_req | input | 27 | Internal peripheral request lines |
| trap_req | input | 1 | Trap instruction request |
| trap_num | input | 2 | Trap number 0..3 |
| cpu_imask | input | 1 | Current I mask bit |
| cpu_umask | input | 1 | Current UI mask bit |
| ue_mode | input | 1 | Mask mode bit |
| ack | input | 1 | Sequencer acknowledge |
| accept | output | 1 | Exception accepted strobe (held) |
| vec_num | output | 8 | Winning vector number |
| new_imask | output | 1 | I bit to load on entry |
| new_umask | output | 1 | UI bit to load on entry |

## Verification
The arbiter is tried with several kinds of input pattern, and each kind separates a different class of fault:
- Single requests on external and internal lines check the vector mapping.
- Pairs at the same level tell lowest-index ordering apart from reversed ordering.
- Pairs whose levels are flipped through each priority register bit show that level outranks index, and that every group bit reaches its own sources.
- Mask and mode combinations show which level each mask bit gates.
- Requests that combine the non-maskable input and the trap input confirm the order above both levels.
- Holding a winner while higher requests arrive distinguishes a held output from a live one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int N_EXT    = 6;
  localparam int N_INT    = 27;
  localparam int N_SRC    = N_EXT + N_INT;
  localparam int N_GRP    = 15;
  localparam int REG_W    = 8;
  localparam int VEC_W    = 8;
  localparam int TRAP_W   = 2;
  localparam int VEC_NMI  = 7;
  localparam int VEC_TRAP = 8;
  localparam int VEC_EXT  = 12;
  localparam int VEC_INT  = 20;

  // Source index s: 0..5 external lines, 6+k internal line k.
  // Group bits: 0..5 ext, 6 watchdog, 7 A/D, 8..10 16-bit timer,
  // 11..12 8-bit timer, 13..14 serial.
  function automatic int grp_of(int s);
    int k;
    k = s - N_EXT;
    if (s < N_EXT)    return s;
    else if (k == 0)  return 6;
    else if (k <= 9)  return 8 + (k - 1) / 3;
    else if (k <= 17) return 11 + (k - 10) / 4;
    else if (k <= 25) return 13 + (k - 18) / 4;
    else              return 7;
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(int s);
    if (s < N_EXT) return VEC_W'(VEC_EXT + s);
    else           return VEC_W'(VEC_INT + s - N_EXT);
  endfunction
endpackage

// File: rtl/irqc_prio_regs.sv
module irqc_prio_regs
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_a,
  input  logic             wr_b,
  input  logic [REG_W-1:0] wdata,
  output logic [N_GRP-1:0] level_grp
);
  logic [N_GRP-1:0] lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (wr_a) lvl_d[REG_W-1:0] = wdata;
    if (wr_b) lvl_d[N_GRP-1:REG_W] = wdata[N_GRP-REG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             lvl_q <= '0;
    else if (wr_a || wr_b)  lvl_q <= lvl_d;
  end

  assign level_grp = lvl_q;
endmodule

// File: rtl/irqc_mask_filter.sv
module irqc_mask_filter
  import irqc_pkg::*;
(
  input  logic [N_GRP-1:0] level_grp,
  input  logic [N_SRC-1:0] req,
  input  logic             imask,
  input  logic             umask,
  input  logic             ue,
  output logic [N_SRC-1:0] cand_hi,
  output logic [N_SRC-1:0] cand_lo
);
  logic [N_SRC-1:0] lvl_src;
  logic             hi_en, lo_en;

  for (genvar s = 0; s < N_SRC; s++) begin : g_map
    assign lvl_src[s] = level_grp[grp_of(s)];
  end

  always_comb begin
    lo_en = !imask;
    hi_en = ue ? !imask : !(imask && umask);
  end

  assign cand_hi = req &  lvl_src & {N_SRC{hi_en}};
  assign cand_lo = req & ~lvl_src & {N_SRC{lo_en}};
endmodule

// File: rtl/irqc_first_set.sv
module irqc_first_set #(
  parameter int N     = 33,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    valid = |vec;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prio_wr_a,
  input  logic                  prio_wr_b,
  input  logic [REG_W-1:0]      prio_wdata,
  input  logic                  nmi_req,
  input  logic [N_EXT-1:0]      ext_req,
  input  logic [N_INT-1:0]      int_req,
  input  logic                  trap_req,
  input  logic [TRAP_W-1:0]     trap_num,
  input  logic                  cpu_imask,
  input  logic                  cpu_umask,
  input  logic                  ue_mode,
  input  logic                  ack,
  output logic                  accept,
  output logic [VEC_W-1:0]      vec_num,
  output logic                  new_imask,
  output logic                  new_umask
);
  localparam int IDX_W = $clog2(N_SRC);

  logic [N_GRP-1:0] level_grp;
  logic [N_SRC-1:0] cand_hi, cand_lo;
  logic             hi_v, lo_v;
  logic [IDX_W-1:0] hi_idx, lo_idx;
  logic             win_v;
  logic [VEC_W-1:0] win_vec;

  logic             acc_q, acc_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             nim_q, nim_d, num_q, num_d;
  logic             acc_en;

  irqc_prio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_a(prio_wr_a), .wr_b(prio_wr_b),
    .wdata(prio_wdata), .level_grp(level_grp)
  );

  irqc_mask_filter u_mask (
    .level_grp(level_grp), .req({int_req, ext_req}),
    .imask(cpu_imask), .umask(cpu_umask), .ue(ue_mode),
    .cand_hi(cand_hi), .cand_lo(cand_lo)
  );

  irqc_first_set #(.N(N_SRC)) u_pick_hi (
    .vec(cand_hi), .valid(hi_v), .idx(hi_idx)
  );

  irqc_first_set #(.N(N_SRC)) u_pick_lo (
    .vec(cand_lo), .valid(lo_v), .idx(lo_idx)
  );

  // Order: non-maskable, trap, level 1, level 0.
  always_comb begin
    win_v   = 1'b1;
    win_vec = '0;
    if (nmi_req)       win_vec = VEC_W'(VEC_NMI);
    else if (trap_req) win_vec = VEC_W'(VEC_TRAP) + VEC_W'(trap_num);
    else if (hi_v)     win_vec = vec_of(int'(hi_idx));
    else if (lo_v)     win_vec = vec_of(int'(lo_idx));
    else               win_v   = 1'b0;
  end

  always_comb begin
    acc_d  = acc_q;
    vec_d  = vec_q;
    nim_d  = nim_q;
    num_d  = num_q;
    acc_en = 1'b0;
    if (acc_q) begin
      if (ack) begin
        acc_d  = 1'b0;
        acc_en = 1'b1;
      end
    end else if (win_v) begin
      acc_d  = 1'b1;
      vec_d  = win_vec;
      nim_d  = 1'b1;
      num_d  = ue_mode ? cpu_umask : 1'b1;
      acc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      vec_q <= '0;
      nim_q <= 1'b0;
      num_q <= 1'b0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      vec_q <= vec_d;
      nim_q <= nim_d;
      num_q <= num_d;
    end
  end

  assign accept    = acc_q;
  assign vec_num   = vec_q;
  assign new_imask = nim_q;
  assign new_umask = num_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_req,
  input logic             trap_req,
  input logic             cpu_imask,
  input logic             cpu_umask,
  input logic             ue_mode,
  input logic             ack,
  input logic             accept,
  input logic [VEC_W-1:0] vec_num,
  input logic             new_imask,
  input logic             new_umask
);
  p_nmi_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && nmi_req) |=> (accept && vec_num == VEC_W'(VEC_NMI)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ack) |=> (accept && $stable(vec_num)));

  p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ack) |=> !accept);

  p_imask_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> new_imask);

  p_ue_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && nmi_req && ue_mode && !cpu_umask) |=> !new_umask);

  p_all_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !nmi_req && !trap_req && ue_mode && cpu_imask) |=> !accept);

  p_vec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (vec_num == VEC_W'(VEC_NMI) ||
                (vec_num >= VEC_W'(VEC_TRAP) && vec_num <= VEC_W'(VEC_EXT + N_EXT - 1)) ||
                (vec_num >= VEC_W'(VEC_INT) && vec_num <= VEC_W'(VEC_INT + N_INT - 1))));
endmodule

bind prio_irq_ctrl irqc_checker u_chk (.*);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prio_wr_a = 0, prio_wr_b = 0;
  logic [7:0]  prio_wdata = 0;
  logic        nmi_req = 0;
  logic [5:0]  ext_req = 0;
  logic [26:0] int_req = 0;
  logic        trap_req = 0;
  logic [1:0]  trap_num = 0;
  logic        cpu_imask = 0, cpu_umask = 0, ue_mode = 0, ack = 0;
  logic        accept;
  logic [7:0]  vec_num;
  logic        new_imask, new_umask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (.*);

  typedef struct packed {
    logic        nmi;
    logic [5:0]  ext;
    logic [26:0] intr;
    logic        trap;
    logic [1:0]  tnum;
    logic        im;
    logic        um;
    logic        ue;
    logic [7:0]  pa;
    logic [7:0]  pb;
    logic        acc;
    logic [7:0]  vec;
    logic        nu;
  } tv_t;

  localparam int NV = 17;
  localparam tv_t TBL [NV] = '{
    // R4: single external line 3 -> 15
    '{1'b0, 6'h08, 27'h0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'd15, 1'b1},
    // R5: lines 1 and 4 same level -> 13
    '{1'b0, 6'h12, 27'h0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'd13, 1'b1},
    // R5: internal k5 and k0 -> 20
    '{1'b0, 6'h00, 27'h21, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'd20, 1'b1},
    // R6: B bit1 lifts k4..6; k0 and k5 -> 25
    '{1'b0, 6'h00, 27'h21, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h02, 1'b1, 8'd25, 1'b1},
    // R6: A bit5 lifts line 5; lines 0 and 5 -> 17
    '{1'b0, 6'h21, 27'h0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h20, 8'h00, 1'b1, 8'd17, 1'b1},
    // R7: ue=1 I=1 masks line 0
    '{1'b0, 6'h01, 27'h0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 8'hff, 8'h00, 1'b0, 8'd0, 1'b0},
    // R2/R10: nmi under full mask, ue=1 um=0 -> 7, new_umask 0
    '{1'b1, 6'h01, 27'h0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 8'd7, 1'b0},
    // R10: ue=1 um=1 copied; line 2 -> 14
    '{1'b0, 6'h04, 27'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 8'd14, 1'b1},
    // R8: ue=0 I=1 UI=0, A bit7 lifts A/D k26 -> 46
    '{1'b0, 6'h04, 27'h4000000, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 8'h80, 8'h00, 1'b1, 8'd46, 1'b1},
    // R8: ue=0 I=1 UI=1 masks level 1 too
    '{1'b0, 6'h04, 27'h4000000, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 8'h80, 8'h00, 1'b0, 8'd0, 1'b0},
    // R8: ue=0 I=1 level-0 only -> none
    '{1'b0, 6'h04, 27'h0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'd0, 1'b0},
    // R3: trap 2 beats masked line 0 -> 10
    '{1'b0, 6'h01, 27'h0, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 8'h01, 8'h00, 1'b1, 8'd10, 1'b1},
    // R2: nmi beats trap -> 7
    '{1'b1, 6'h00, 27'h0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'd7, 1'b1},
    // R6: B bit6 lifts serial k22..25; k25 vs k11 -> 45
    '{1'b0, 6'h00, 27'h2000800, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h40, 1'b1, 8'd45, 1'b1},
    // R8: ue=0 I=0 UI=1 keeps level 0 open -> 13
    '{1'b0, 6'h02, 27'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 8'd13, 1'b1},
    // R3: trap 3 alone -> 11
    '{1'b0, 6'h00, 27'h0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'd11, 1'b1},
    // R4: internal k17 alone -> 37
    '{1'b0, 6'h00, 27'h20000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'd37, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_reqs();
    nmi_req = 0; ext_req = 0; int_req = 0; trap_req = 0; trap_num = 0;
  endtask

  task automatic write_prio(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk); prio_wdata = a; prio_wr_a = 1;
    @(negedge clk); prio_wr_a = 0; prio_wdata = b; prio_wr_b = 1;
    @(negedge clk); prio_wr_b = 0;
  endtask

  task automatic run_vec(input tv_t v, input int n);
    write_prio(v.pa, v.pb);
    cpu_imask = v.im; cpu_umask = v.um; ue_mode = v.ue;
    nmi_req = v.nmi; ext_req = v.ext; int_req = v.intr;
    trap_req = v.trap; trap_num = v.tnum;
    @(negedge clk);
    check(accept == v.acc, $sformatf("R9 vec%0d accept", n), accept, v.acc);
    if (v.acc) begin
      check(vec_num == v.vec, $sformatf("R5 vec%0d vector", n), vec_num, v.vec);
      check(new_imask == 1'b1, $sformatf("R10 vec%0d new_imask", n), new_imask, 1);
      check(new_umask == v.nu, $sformatf("R10 vec%0d new_umask", n), new_umask, v.nu);
    end
    clear_reqs();
    ack = 1;
    @(negedge clk);
    ack = 0;
    check(accept == 1'b0, $sformatf("R9 vec%0d cleared", n), accept, 0);
    cpu_imask = 0; cpu_umask = 0; ue_mode = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(accept == 0, "R1 accept", accept, 0);
    check(vec_num == 0, "R1 vec_num", vec_num, 0);
    check(new_imask == 0 && new_umask == 0, "R1 masks", {new_imask, new_umask}, 0);
    rst_n = 1;
    @(negedge clk);
    check(accept == 0, "R1 idle", accept, 0);

    for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

    // R9: hold against a later non-maskable request
    write_prio(8'h00, 8'h00);
    ext_req = 6'h01;
    @(negedge clk);
    check(accept && vec_num == 12, "R9 capture", vec_num, 12);
    ext_req = 0; nmi_req = 1;
    repeat (2) @(negedge clk);
    check(accept && vec_num == 12, "R9 held", vec_num, 12);
    ack = 1;
    @(negedge clk);
    ack = 0;
    check(accept == 0, "R9 ack gap", accept, 0);
    @(negedge clk);
    check(accept && vec_num == 7, "R9 rearbitrate", vec_num, 7);
    nmi_req = 0; ack = 1;
    @(negedge clk);
    ack = 0;

    // R1: reset returns groups to level 0 (B bit0 lifts k1..3)
    write_prio(8'h00, 8'h01);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    ext_req = 6'h01; int_req = 27'h2;
    @(negedge clk);
    check(accept && vec_num == 12, "R1 levels reset", vec_num, 12);
    clear_reqs(); ack = 1;
    @(negedge clk);
    ack = 0;

    // R6: register B bit 7 ignored, external line 1 stays below k1
    write_prio(8'h00, 8'h81);
    ext_req = 6'h02; int_req = 27'h2;
    @(negedge clk);
    check(accept && vec_num == 21, "R6 bit7 ignored, B bit0 lifts k1", vec_num, 21);
    clear_reqs(); ack = 1;
    @(negedge clk);
    ack = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule